// File: doc/BRIEF.md
# DMA Page Translation Unit

This block maps the logical addresses issued by a DMA engine onto physical memory addresses, one 4 KB page at a time. It uses a local table of up to 512 page entries. Software fills the table through an entry write port. Each entry is eight bytes wide: a frame word that gives the physical page, and an owner word that has no effect on the mapping. Two configuration registers hold the table's base address and its size in bytes. A size of zero turns translation off.

A DMA engine offers a logical address with a valid/ready handshake. The following cycle the block returns a registered response. That response carries either the physical address (the frame's page bits joined to the unchanged page offset) or a fault. A fault is reported when translation is off, when the page number falls outside the programmed table size, or when the entry's frame word is zero. A one-cycle fault pulse marks each new faulting response for interrupt or error logic.

Top module: `dma_page_xlate`

## Requirements
- R1: After reset, resp_valid and fault_pulse are 0, tbl_window_addr is 0, the table size is 0 and every entry is unmapped.
- R2: For a successful translation, resp_paddr[11:0] equals bits [11:0] of the logical address that was accepted.
- R3: A successful translation uses the entry selected by the page number laddr[31:12]. It returns resp_paddr = {frame[31:12], laddr[11:0]} with resp_fault = 0.
- R4: A request whose entry has an all-zero frame word faults.
- R5: The usable entry count is the size register shifted right by 3 (bits [2:0] ignored), capped at 512. A page number at or above that count faults.
- R6: While the size register is zero, every request faults.
- R7: cfg_sel = 0 writes the table base and cfg_sel = 1 writes the table size. tbl_window_addr shows the base with bit 31 forced to 0, from the cycle after the write.
- R8: ent_sel = 0 writes the frame word of entry ent_idx and ent_sel = 1 writes its owner word. A frame write affects requests accepted in later cycles only; a request accepted in the same cycle sees the old frame. Owner writes never change a translation.
- R9: req_ready equals !resp_valid || resp_ready. The response appears in the cycle after acceptance. It holds stable while resp_valid is 1 and resp_ready is 0. It clears after being consumed when no new request is accepted.
- R10: A faulting response has resp_fault = 1 and resp_paddr = 0. fault_pulse is 1 for exactly the first cycle that response is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects table size in bytes |
| cfg_wdata | input | 32 | Configuration write data |
| tbl_window_addr | output | 32 | Table base as a physical address, bit 31 cleared |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | 9 | Entry index |
| ent_sel | input | 1 | 0 selects frame word, 1 selects owner word |
| ent_wdata | input | 32 | Entry write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_laddr | input | 32 | Logical address |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_fault | output | 1 | Translation fault |
| resp_paddr | output | 32 | Physical address, 0 on fault |
| fault_pulse | output | 1 | One-cycle marker of a new faulting response |

## Verification
A corrupted mapped bit or frame entry shows up in the response one cycle after the next request to that page: a wrong fault, or a wrong upper address. A wrong entry count shows up at the first request near the table boundary. The bench therefore probes pages on both sides of each programmed size, including the 512-entry cap. A broken hold path shows up in the first backpressured cycle, as a response that changes or drops while resp_ready is low. Every clock, the outputs are compared against a behavioural model, so any such error is caught in the cycle it first reaches a port.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
   typedef enum logic {
      CFG_BASE  = 1'b0,
      CFG_LIMIT = 1'b1
   } cfg_sel_e;

   typedef enum logic {
      WORD_FRAME = 1'b0,
      WORD_OWNER = 1'b1
   } ent_word_e;
endpackage

// File: rtl/dpx_cfg_regs.sv
module dpx_cfg_regs #(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 9,
   parameter int ENT_SHIFT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              sel,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] window_addr,
   output logic [IDX_W:0]    ent_count
);
   import dpx_pkg::*;

   localparam int SPAN_SHIFT = IDX_W + ENT_SHIFT;

   logic [ADDR_W-2:0] base_q;
   logic [ADDR_W-1:0] limit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         limit_q <= '0;
      end else if (we) begin
         if (sel == CFG_BASE) base_q  <= wdata[ADDR_W-2:0];
         else                 limit_q <= wdata;
      end
   end

   assign window_addr = {1'b0, base_q};

   logic lint_unused_low;
   assign lint_unused_low = ^limit_q[ENT_SHIFT-1:0];

   generate
      if (ADDR_W > SPAN_SHIFT) begin : g_cap
         logic over;
         assign over = |limit_q[ADDR_W-1:SPAN_SHIFT];
         assign ent_count = over ? (IDX_W+1)'(1 << IDX_W)
                                 : {1'b0, limit_q[SPAN_SHIFT-1:ENT_SHIFT]};
      end else begin : g_nocap
         assign ent_count = {1'b0, limit_q[SPAN_SHIFT-1:ENT_SHIFT]};
      end
   endgenerate
endmodule

// File: rtl/dpx_entry_store.sv
module dpx_entry_store #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_BITS   = 12,
   parameter int MAX_ENTRIES = 512
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               we,
   input  logic                               sel,
   input  logic [$clog2(MAX_ENTRIES)-1:0]     wr_idx,
   input  logic [ADDR_W-1:0]                  wdata,
   input  logic [$clog2(MAX_ENTRIES)-1:0]     rd_idx,
   output logic [ADDR_W-PAGE_BITS-1:0]        rd_frame,
   output logic                               rd_mapped
);
   import dpx_pkg::*;

   localparam int FRAME_W = ADDR_W - PAGE_BITS;

   logic [MAX_ENTRIES-1:0] mapped_q;
   logic [FRAME_W-1:0]     frame_q [MAX_ENTRIES];

   logic frame_wr;
   assign frame_wr = we && (sel == WORD_FRAME);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mapped_q         <= '0;
      else if (frame_wr) mapped_q[wr_idx] <= |wdata;
   end

   always_ff @(posedge clk) begin
      if (frame_wr) frame_q[wr_idx] <= wdata[ADDR_W-1:PAGE_BITS];
   end

   assign rd_frame  = frame_q[rd_idx];
   assign rd_mapped = mapped_q[rd_idx];
endmodule

// File: rtl/dpx_resp_stage.sv
module dpx_resp_stage #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   parameter int IDX_W     = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [ADDR_W-1:0]           req_laddr,
   input  logic [IDX_W:0]              ent_count,
   input  logic [ADDR_W-PAGE_BITS-1:0] rd_frame,
   input  logic                        rd_mapped,
   input  logic                        resp_ready,
   output logic                        req_ready,
   output logic                        resp_valid,
   output logic                        resp_fault,
   output logic [ADDR_W-1:0]           resp_paddr,
   output logic                        fault_pulse
);
   localparam int VPN_W = ADDR_W - PAGE_BITS;

   logic [VPN_W-1:0]  vpn;
   logic              in_range;
   logic              fault_d;
   logic [ADDR_W-1:0] paddr_d;
   logic              accept;

   assign vpn      = req_laddr[ADDR_W-1:PAGE_BITS];
   assign in_range = vpn < VPN_W'(ent_count);
   assign fault_d  = !in_range || !rd_mapped;
   assign paddr_d  = fault_d ? '0 : {rd_frame, req_laddr[PAGE_BITS-1:0]};

   assign req_ready = !resp_valid || resp_ready;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid  <= 1'b0;
         resp_fault  <= 1'b0;
         resp_paddr  <= '0;
         fault_pulse <= 1'b0;
      end else begin
         fault_pulse <= accept && fault_d;
         if (accept) begin
            resp_valid <= 1'b1;
            resp_fault <= fault_d;
            resp_paddr <= paddr_d;
         end else if (resp_ready) begin
            resp_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dma_page_xlate.sv
module dma_page_xlate #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_BITS   = 12,
   parameter int MAX_ENTRIES = 512,
   parameter int ENT_BYTES   = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic                           cfg_sel,
   input  logic [ADDR_W-1:0]              cfg_wdata,
   output logic [ADDR_W-1:0]              tbl_window_addr,
   input  logic                           ent_we,
   input  logic [$clog2(MAX_ENTRIES)-1:0] ent_idx,
   input  logic                           ent_sel,
   input  logic [ADDR_W-1:0]              ent_wdata,
   input  logic                           req_valid,
   output logic                           req_ready,
   input  logic [ADDR_W-1:0]              req_laddr,
   output logic                           resp_valid,
   input  logic                           resp_ready,
   output logic                           resp_fault,
   output logic [ADDR_W-1:0]              resp_paddr,
   output logic                           fault_pulse
);
   localparam int IDX_W     = $clog2(MAX_ENTRIES);
   localparam int ENT_SHIFT = $clog2(ENT_BYTES);
   localparam int FRAME_W   = ADDR_W - PAGE_BITS;

   generate
      if ((1 << IDX_W) != MAX_ENTRIES) begin : g_bad_depth
         $error("MAX_ENTRIES must be a power of two");
      end
      if ((1 << ENT_SHIFT) != ENT_BYTES) begin : g_bad_ent
         $error("ENT_BYTES must be a power of two");
      end
      if (PAGE_BITS + IDX_W > ADDR_W || IDX_W + ENT_SHIFT > ADDR_W) begin : g_bad_width
         $error("ADDR_W too narrow for page size and table depth");
      end
   endgenerate

   logic [IDX_W:0]       ent_count;
   logic [FRAME_W-1:0]   rd_frame;
   logic                 rd_mapped;
   logic [IDX_W-1:0]     rd_idx;

   assign rd_idx = req_laddr[PAGE_BITS+IDX_W-1:PAGE_BITS];

   dpx_cfg_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENT_SHIFT(ENT_SHIFT)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .window_addr(tbl_window_addr), .ent_count(ent_count)
   );

   dpx_entry_store #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .MAX_ENTRIES(MAX_ENTRIES)) u_store (
      .clk(clk), .rst_n(rst_n), .we(ent_we), .sel(ent_sel), .wr_idx(ent_idx),
      .wdata(ent_wdata), .rd_idx(rd_idx), .rd_frame(rd_frame), .rd_mapped(rd_mapped)
   );

   dpx_resp_stage #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_resp (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
      .ent_count(ent_count), .rd_frame(rd_frame), .rd_mapped(rd_mapped),
      .resp_ready(resp_ready), .req_ready(req_ready), .resp_valid(resp_valid),
      .resp_fault(resp_fault), .resp_paddr(resp_paddr), .fault_pulse(fault_pulse)
   );
endmodule

// File: rtl/dpx_checker.sv
module dpx_checker #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              cfg_sel,
   input logic [ADDR_W-1:0] cfg_wdata,
   input logic [ADDR_W-1:0] tbl_window_addr,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_laddr,
   input logic              resp_valid,
   input logic              resp_ready,
   input logic              resp_fault,
   input logic [ADDR_W-1:0] resp_paddr,
   input logic              fault_pulse
);
   logic [PAGE_BITS-1:0] acc_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      acc_off <= '0;
      else if (req_valid && req_ready) acc_off <= req_laddr[PAGE_BITS-1:0];
   end

   p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_fault |-> resp_paddr[PAGE_BITS-1:0] == acc_off);

   p_base_msb_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && !cfg_sel |=> tbl_window_addr == {1'b0, $past(cfg_wdata[ADDR_W-2:0])});

   p_accept_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> resp_valid);

   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_ready |=> resp_valid && $stable(resp_paddr) && $stable(resp_fault));

   p_pulse_on_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |-> resp_valid && resp_fault && resp_paddr == '0);
endmodule

bind dma_page_xlate dpx_checker #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
   .tbl_window_addr(tbl_window_addr), .req_valid(req_valid), .req_ready(req_ready),
   .req_laddr(req_laddr), .resp_valid(resp_valid), .resp_ready(resp_ready),
   .resp_fault(resp_fault), .resp_paddr(resp_paddr), .fault_pulse(fault_pulse)
);

// File: tb/dma_page_xlate_tb_top.sv
`timescale 1ns/1ps
module dma_page_xlate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0, cfg_sel = 0;
   logic [31:0] cfg_wdata = 0;
   logic [31:0] tbl_window_addr;
   logic        ent_we = 0, ent_sel = 0;
   logic [8:0]  ent_idx = 0;
   logic [31:0] ent_wdata = 0;
   logic        req_valid = 0, req_ready;
   logic [31:0] req_laddr = 0;
   logic        resp_valid, resp_ready = 1, resp_fault, fault_pulse;
   logic [31:0] resp_paddr;

   always #10 clk = ~clk;

   dma_page_xlate dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .tbl_window_addr(tbl_window_addr), .ent_we(ent_we), .ent_idx(ent_idx),
      .ent_sel(ent_sel), .ent_wdata(ent_wdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_laddr(req_laddr), .resp_valid(resp_valid), .resp_ready(resp_ready),
      .resp_fault(resp_fault), .resp_paddr(resp_paddr), .fault_pulse(fault_pulse)
   );

   // behavioural reference model
   logic [31:0] m_frame [512];
   logic [31:0] m_base, m_limit;
   logic        e_rv, e_fault, e_pulse;
   logic [31:0] e_paddr;
   string       e_tag;
   int          n_checks = 0, n_fail = 0;
   bit          done = 0;

   task automatic model_xl(input logic [31:0] la, output logic f, output logic [31:0] pa,
                           output string tag);
      longint unsigned cnt, vpn;
      vpn = la >> 12;
      cnt = (m_limit >= 32'h1000) ? 512 : (m_limit >> 3);
      pa = 0; f = 1;
      if (m_limit == 0)             tag = "R6";
      else if (vpn >= cnt)          tag = "R5";
      else if (m_frame[vpn] == 0)   tag = "R4";
      else begin
         tag = "R3"; f = 0;
         pa = {m_frame[vpn][31:12], la[11:0]};
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 512; i++) m_frame[i] = 0;
         m_base = 0; m_limit = 0;
         e_rv = 0; e_fault = 0; e_pulse = 0; e_paddr = 0; e_tag = "R1";
      end else begin
         logic acc, f;
         logic [31:0] pa;
         string tg;
         acc = req_valid && (!e_rv || resp_ready);
         e_pulse = 0;
         if (acc) begin
            model_xl(req_laddr, f, pa, tg);
            e_rv = 1; e_fault = f; e_paddr = pa; e_tag = tg; e_pulse = f;
         end else if (resp_ready) e_rv = 0;
         if (cfg_we) begin
            if (cfg_sel) m_limit = cfg_wdata;
            else         m_base = cfg_wdata;
         end
         if (ent_we && !ent_sel) m_frame[ent_idx] = ent_wdata;
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req,
                      input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk({31'b0, resp_valid}, {31'b0, e_rv}, "R9", "resp_valid");
      chk({31'b0, req_ready}, {31'b0, !e_rv || resp_ready}, "R9", "req_ready");
      chk({31'b0, fault_pulse}, {31'b0, e_pulse}, "R10", "fault_pulse");
      chk(tbl_window_addr, {1'b0, m_base[30:0]}, "R7", "window");
      if (e_rv) begin
         chk({31'b0, resp_fault}, {31'b0, e_fault}, e_tag, "resp_fault");
         chk(resp_paddr, e_paddr, e_fault ? "R10" : e_tag, "resp_paddr");
         if (!e_fault) chk({20'b0, resp_paddr[11:0]}, {20'b0, e_paddr[11:0]}, "R2", "offset");
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare_all();
      cfg_we = 0; ent_we = 0; req_valid = 0;
   endtask

   task automatic cfg_wr(input logic s, input logic [31:0] d);
      cfg_we = 1; cfg_sel = s; cfg_wdata = d; tick();
   endtask

   task automatic ent_wr(input int idx, input logic s, input logic [31:0] d);
      ent_we = 1; ent_idx = 9'(idx); ent_sel = s; ent_wdata = d; tick();
   endtask

   task automatic xreq(input logic [31:0] la);
      req_valid = 1; req_laddr = la; tick();
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({31'b0, resp_valid}, 32'd0, "R1", "reset resp_valid");
      chk({31'b0, fault_pulse}, 32'd0, "R1", "reset fault_pulse");
      chk(tbl_window_addr, 32'd0, "R1", "reset window");
      rst_n = 1;
      tick();
      // R6: size zero, all fault (even mapped pages)
      ent_wr(0, 0, 32'h0001_2000);
      xreq(32'h0000_0123);
      xreq(32'h0003_4abc);
      tick();
      // R5/R3/R4: five usable entries, bits [2:0] of size ignored
      cfg_wr(1, 32'h0000_002F);
      ent_wr(1, 0, 32'h8000_0FFF);
      ent_wr(4, 0, 32'hABCD_E000);
      ent_wr(5, 0, 32'h1111_1000);
      ent_wr(511, 0, 32'hFFFF_F000);
      xreq(32'h0000_0ABC);
      xreq(32'h0000_1FFF);
      xreq(32'h0000_2000);   // unmapped, R4
      xreq(32'h0000_4555);   // last usable
      xreq(32'h0000_5000);   // first out of range, R5
      // R5: cap at 512
      cfg_wr(1, 32'hFFFF_FFFF);
      xreq(32'h001F_F321);
      xreq(32'h0020_0000);
      xreq(32'hFFFF_F000);
      cfg_wr(1, 32'h0000_1000);
      xreq(32'h001F_F001);
      cfg_wr(1, 32'h0000_0FFF);   // 511 entries
      xreq(32'h001F_E000);
      xreq(32'h001F_F000);
      // R8: owner write keeps mapping; frame write visible next cycle only
      ent_wr(4, 1, 32'h0000_0000);
      xreq(32'h0000_4777);
      ent_we = 1; ent_idx = 4; ent_sel = 0; ent_wdata = 0;
      req_valid = 1; req_laddr = 32'h0000_4001; tick();   // sees old frame
      xreq(32'h0000_4001);                                 // now unmapped
      ent_wr(4, 0, 32'h0000_0001);                         // nonzero low bits map page 0
      xreq(32'h0000_4ABC);
      // R7: base bit 31 dropped
      cfg_wr(0, 32'hFFFF_FFFF);
      cfg_wr(0, 32'h8123_4000);
      // R9: backpressure hold and back-to-back
      resp_ready = 0;
      xreq(32'h0000_1010);
      req_valid = 1; req_laddr = 32'h0000_0020; tick();
      req_valid = 1; req_laddr = 32'h0000_0020; tick();
      resp_ready = 1;
      req_valid = 1; req_laddr = 32'h0000_0020; tick();
      xreq(32'h0000_5000);
      xreq(32'h0000_6000);
      tick();
      // random mix
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom_range(0, 99);
         resp_ready = ($urandom_range(0, 3) != 0);
         if (r < 10) begin
            cfg_we = 1; cfg_sel = $urandom_range(0, 1);
            cfg_wdata = (cfg_sel) ? 32'($urandom_range(0, 140)) : $urandom;
         end else if (r < 30) begin
            ent_we = 1; ent_idx = 9'($urandom_range(0, 15)); ent_sel = $urandom_range(0, 1);
            ent_wdata = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
         end
         req_valid = ($urandom_range(0, 2) != 0);
         req_laddr = {12'($urandom_range(0, 2)), 8'($urandom_range(0, 17)), 12'($urandom)};
         tick();
      end
      resp_ready = 1;
      tick();
      tick();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule